// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a small set of external interrupt pins and turns their activity into pending flags, an interrupt request and a wake request. Each pin has its own two-bit sense selector. Three of the settings are edge modes: any change, falling edge and rising edge. The fourth setting is low level. Edge modes run in the I/O clock domain. They use a two-flop synchronizer and a latched pending flag, and software clears that flag with a write-one-to-clear strobe or with an acknowledge pulse. Low-level mode keeps no flag: its request follows the synchronized pin for as long as the pin stays low.

During deep sleep the I/O clock is treated as absent, so no edge is detected. A separate slow, always-on sampling clock watches every armed low-level pin and raises a wake request once it has seen the pin low on two consecutive samples. The wake request stays up until the start-up logic signals completion. Level requests are held off until that point. The pin is then judged again, so a level that went away during start-up still wakes the device but raises no interrupt.

An interrupt reaches the core only when the global enable and the pin's own mask bit are both set.

Top module: `ext_irq_sense`

## Requirements
- R1: For pin i, `sense_i[2i+1:2i]` selects the mode: 2'b00 low level, 2'b01 any change, 2'b10 falling edge, 2'b11 rising edge. An edge of the other kind from the one selected leaves the flag clear.
- R2: `irq_o` is high exactly when `gie_i` is high and some pin has both `pend_o[i]` and `mask_i[i]` high. A masked pin still shows its pending bit.
- R3: In an edge mode, a pin change that lasts at least one I/O clock period and is sampled on a rising edge of `clk_io` sets `pend_o[i]` on the third rising edge after the change. This includes a low pulse of one cycle on a pin in rising-edge mode.
- R4: An edge flag is cleared on the edge where `clr_i[i]` or `ack_i[i]` is sampled high. If a new detection happens on that same edge, the detection wins.
- R5: In low-level mode, `pend_o[i]` goes high on the second I/O edge after the pin falls and stays high while the pin is held low. It drops on the second edge after the pin rises, since no flag is latched.
- R6: An edge flag stays set until it is cleared by R4 or the pin is put into low-level mode.
- R7: While `sleep_i` is high, no edge is detected and the low-level `pend_o` bits read 0.
- R8: While `sleep_i` is high, a pin in low-level mode with its mask bit set that is seen low on two consecutive rising edges of `clk_wdt` raises `wake_o` on the second of those edges. A single low sample, or a masked pin, gives no wake.
- R9: `wake_o` stays high until `start_done_i` is sampled high on a `clk_wdt` edge. While `wake_o` is high, low-level requests stay at 0. After that edge the request reflects the pin again, so a pin already released gives no interrupt.
- R10: After reset (`rst_n` low over clock edges) every pending flag, `irq_o` and `wake_o` read 0, and the synchronizers hold the idle-high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_io | input | 1 | I/O clock for synchronizers and edge flags |
| clk_wdt | input | 1 | slow always-on sampling clock for the wake path |
| rst_n | input | 1 | synchronous active-low reset, seen by both clocks |
| pin_i | input | NPINS | external interrupt pins |
| sense_i | input | 2*NPINS | per-pin sense mode, two bits per pin |
| mask_i | input | NPINS | per-pin interrupt mask, 1 enables the pin |
| gie_i | input | 1 | global interrupt enable |
| clr_i | input | NPINS | write-one-to-clear strobe for edge flags |
| ack_i | input | NPINS | interrupt acknowledge, clears the edge flag |
| sleep_i | input | 1 | deep sleep, I/O clock treated as stopped |
| start_done_i | input | 1 | end of the start-up period, sampled on clk_wdt |
| pend_o | output | NPINS | per-pin pending request |
| irq_o | output | 1 | combined interrupt request |
| wake_o | output | 1 | wake request from deep sleep |

## Verification
The bench targets the latency of the synchronizer and the edge detector with a one-cycle pulse. A design that detected edges on the raw pin, or that dropped a stage, would set the flag one cycle early, and a design missing short pulses would not set it at all. It drives a clear and a new detection on the same edge to show that the detection wins, and it shows that a low level leaves no latched flag once the pin rises. For the wake path, a single low sample must not wake the device. A level released during start-up must wake the device without an interrupt, and one still held low must raise the interrupt right after start-up completes. A design that latched the level, or that let level requests through before start-up completed, would raise `irq_o` where none is due.

// File: rtl/ext_irq_pkg.sv
// Package: shared sense-mode type and the edge decision for the
// external interrupt sense controller.
// Assumes: mode encoding is fixed by the software-visible field.
package ext_irq_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    // Decide whether the transition old_v -> now_v matches an edge mode.
    function automatic logic edge_match(sense_e mode, logic now_v, logic old_v);
        logic res;
        case (mode)
            SENSE_ANY:  res = now_v ^ old_v;
            SENSE_FALL: res = old_v & ~now_v;
            SENSE_RISE: res = ~old_v & now_v;
            default:    res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
// Module: multi-flop synchronizer for one interrupt pin.
// Resets to the idle-high level, so a pin that sits high after reset
// is not mistaken for a rising edge.
// Assumes: STAGES >= 2.
module ext_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the raw pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/ext_irq_edge.sv
// Module: edge detector and sticky pending flag for one pin.
// Compares the synchronized pin with its previous value. It sets the
// flag on a match for the selected edge mode, and clears the flag on a
// clear request; a detection on the same edge wins. In low-level mode
// the flag is held at zero.
// Assumes: cur is already synchronous to clk.
module ext_irq_edge
    import ext_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  sense_e mode,
    input  logic   detect_en,
    input  logic   cur,
    input  logic   clr,
    output logic   flag
);

    logic prev;
    logic hit;

    // Keep the previous synchronized sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= cur;
    end

    // Detection qualified by the I/O clock being logically present.
    always_comb hit = detect_en & edge_match(mode, cur, prev);

    // Sticky flag: set on detection, cleared by request, zero in level mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag <= 1'b0;
        else if (mode == SENSE_LOW) flag <= 1'b0;
        else if (hit)              flag <= 1'b1;
        else if (clr)              flag <= 1'b0;
    end

endmodule

// File: rtl/ext_irq_wake.sv
// Module: low-level wake sampler in the slow always-on clock domain.
// It counts consecutive low samples of every armed pin while in deep
// sleep. When any pin reaches SAMPLES, it latches a wake request that
// is held until the start-up period ends.
// Assumes: pins are sampled raw; the repeated samples are the noise
// filter, and the clock is slow compared with settling.
module ext_irq_wake #(
    parameter int NPINS   = 2,
    parameter int SAMPLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic [NPINS-1:0] armed,
    input  logic [NPINS-1:0] pin,
    input  logic             start_done,
    output logic             wake
);

    localparam int CW = $clog2(SAMPLES + 1);

    logic [NPINS-1:0] reach;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic [CW-1:0] cnt;
        logic          low_ok;

        // A sample counts only when sleeping, armed and low.
        always_comb low_ok = sleep & armed[g] & ~pin[g];

        // Consecutive low-sample counter, saturating at SAMPLES.
        always_ff @(posedge clk) begin
            if (!rst_n || !low_ok)          cnt <= '0;
            else if (cnt != CW'(SAMPLES))   cnt <= cnt + 1'b1;
        end

        // Fires on the sample that completes the required run.
        always_comb reach[g] = low_ok & (cnt == CW'(SAMPLES - 1));
    end

    // Wake latch: set on a completed run, released at end of start-up.
    always_ff @(posedge clk) begin
        if (!rst_n)         wake <= 1'b0;
        else if (start_done) wake <= 1'b0;
        else if (|reach)    wake <= 1'b1;
    end

endmodule

// File: rtl/ext_irq_sense.sv
// Module: top of the external interrupt sense controller.
// Per pin: synchronizer, edge flag and level request. A shared wake
// sampler runs on the slow clock. Level requests are gated off while
// sleeping or while a wake is still waiting for start-up to end.
// Assumes: rst_n is held low across edges of both clocks.
module ext_irq_sense
    import ext_irq_pkg::*;
#(
    parameter int NPINS        = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int WAKE_SAMPLES = 2
) (
    input  logic               clk_io,
    input  logic               clk_wdt,
    input  logic               rst_n,
    input  logic [NPINS-1:0]   pin_i,
    input  logic [2*NPINS-1:0] sense_i,
    input  logic [NPINS-1:0]   mask_i,
    input  logic               gie_i,
    input  logic [NPINS-1:0]   clr_i,
    input  logic [NPINS-1:0]   ack_i,
    input  logic               sleep_i,
    input  logic               start_done_i,
    output logic [NPINS-1:0]   pend_o,
    output logic               irq_o,
    output logic               wake_o
);

    logic [NPINS-1:0] armed;
    logic             level_open;

    // Level requests pass only when awake and start-up has completed.
    always_comb level_open = ~sleep_i & ~wake_o;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        sense_e mode;
        logic   pin_s;
        logic   edge_flag;

        // Decode this pin's mode field.
        always_comb mode = sense_e'(sense_i[2*g +: 2]);

        ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk_io),
            .rst_n (rst_n),
            .d     (pin_i[g]),
            .q     (pin_s)
        );

        ext_irq_edge u_edge (
            .clk       (clk_io),
            .rst_n     (rst_n),
            .mode      (mode),
            .detect_en (~sleep_i),
            .cur       (pin_s),
            .clr       (clr_i[g] | ack_i[g]),
            .flag      (edge_flag)
        );

        // Pending view: live level in low mode, latched flag otherwise.
        always_comb pend_o[g] = (mode == SENSE_LOW) ? (~pin_s & level_open) : edge_flag;

        // Wake arming: only enabled low-level pins may wake the device.
        always_comb armed[g] = (mode == SENSE_LOW) & mask_i[g];
    end

    ext_irq_wake #(.NPINS(NPINS), .SAMPLES(WAKE_SAMPLES)) u_wake (
        .clk        (clk_wdt),
        .rst_n      (rst_n),
        .sleep      (sleep_i),
        .armed      (armed),
        .pin        (pin_i),
        .start_done (start_done_i),
        .wake       (wake_o)
    );

    // Combined request: global enable over masked pending pins.
    always_comb irq_o = gie_i & |(pend_o & mask_i);

endmodule

// File: rtl/ext_irq_sense_chk.sv
// Checker: temporal properties of the external interrupt sense
// controller, bound to the top module.
module ext_irq_sense_chk #(
    parameter int NPINS = 2
) (
    input logic               clk_io,
    input logic               clk_wdt,
    input logic               rst_n,
    input logic [NPINS-1:0]   pin_i,
    input logic [2*NPINS-1:0] sense_i,
    input logic [NPINS-1:0]   mask_i,
    input logic               gie_i,
    input logic [NPINS-1:0]   clr_i,
    input logic [NPINS-1:0]   ack_i,
    input logic               sleep_i,
    input logic               start_done_i,
    input logic [NPINS-1:0]   pend_o,
    input logic               irq_o,
    input logic               wake_o
);

    logic up;

    // Marks that at least one edge has passed since reset.
    always_ff @(posedge clk_io) begin
        if (!rst_n) up <= 1'b0;
        else        up <= 1'b1;
    end

    AST_IRQ_SOURCE: assert property (@(posedge clk_io) disable iff (!rst_n)
        irq_o |-> (gie_i && |(pend_o & mask_i))); // R2

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic lvl;
        always_comb lvl = (sense_i[2*g +: 2] == 2'b00);

        AST_LEVEL_FOLLOWS: assert property (@(posedge clk_io) disable iff (!rst_n)
            (up && lvl && $past(!pin_i[g])) |=> (pend_o[g] || sleep_i || wake_o || !lvl)); // R5

        AST_EDGE_STICKY: assert property (@(posedge clk_io) disable iff (!rst_n)
            (!lvl && pend_o[g] && !clr_i[g] && !ack_i[g]) |=> (pend_o[g] || lvl)); // R6

        AST_NO_EDGE_ASLEEP: assert property (@(posedge clk_io) disable iff (!rst_n)
            (!lvl && sleep_i && !pend_o[g]) |=> (!pend_o[g] || lvl)); // R7
    end

    AST_WAKE_FROM_SLEEP: assert property (@(posedge clk_wdt) disable iff (!rst_n)
        $rose(wake_o) |-> $past(sleep_i)); // R8

    AST_WAKE_RELEASE: assert property (@(posedge clk_wdt) disable iff (!rst_n)
        start_done_i |=> !wake_o); // R9

endmodule

bind ext_irq_sense ext_irq_sense_chk #(.NPINS(NPINS)) u_chk (
    .clk_io       (clk_io),
    .clk_wdt      (clk_wdt),
    .rst_n        (rst_n),
    .pin_i        (pin_i),
    .sense_i      (sense_i),
    .mask_i       (mask_i),
    .gie_i        (gie_i),
    .clr_i        (clr_i),
    .ack_i        (ack_i),
    .sleep_i      (sleep_i),
    .start_done_i (start_done_i),
    .pend_o       (pend_o),
    .irq_o        (irq_o),
    .wake_o       (wake_o)
);

// File: tb/ext_irq_sense_test.sv
// Bench: directed stimulus plus a behavioural reference model that is
// compared with the outputs on every I/O clock.
module ext_irq_sense_test;

    logic       clk_io = 1'b0;
    logic       clk_wdt = 1'b0;
    logic       rst_n;
    logic [1:0] pin_i;
    logic [3:0] sense_i;
    logic [1:0] mask_i;
    logic       gie_i;
    logic [1:0] clr_i;
    logic [1:0] ack_i;
    logic       sleep_i;
    logic       start_done_i;
    logic [1:0] pend_o;
    logic       irq_o;
    logic       wake_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    ext_irq_sense uut (
        .clk_io       (clk_io),
        .clk_wdt      (clk_wdt),
        .rst_n        (rst_n),
        .pin_i        (pin_i),
        .sense_i      (sense_i),
        .mask_i       (mask_i),
        .gie_i        (gie_i),
        .clr_i        (clr_i),
        .ack_i        (ack_i),
        .sleep_i      (sleep_i),
        .start_done_i (start_done_i),
        .pend_o       (pend_o),
        .irq_o        (irq_o),
        .wake_o       (wake_o)
    );

    // 250 MHz I/O clock; slow clock of 40 ns rising on I/O rising edges.
    always #2 clk_io = ~clk_io;
    initial begin
        #2;
        forever #20 clk_wdt = ~clk_wdt;
    end

    // ---------------- reference model ----------------
    logic [1:0] hist[$];
    logic [1:0] mflag;
    int         mcnt[2];
    logic       mwake;

    initial begin
        hist  = '{2'b11, 2'b11, 2'b11, 2'b11};
        mflag = 2'b00;
        mwake = 1'b0;
        mcnt[0] = 0;
        mcnt[1] = 0;
    end

    always @(posedge clk_io) begin
        if (!rst_n) begin
            hist  = '{2'b11, 2'b11, 2'b11, 2'b11};
            mflag = 2'b00;
        end else begin
            hist.push_front(pin_i);
            void'(hist.pop_back());
            for (int i = 0; i < 2; i++) begin
                logic [1:0] md;
                logic now_v, old_v, hit;
                md    = sense_i[2*i +: 2];
                now_v = hist[2][i];
                old_v = hist[3][i];
                case (md)
                    2'b01:   hit = now_v != old_v;
                    2'b10:   hit = old_v && !now_v;
                    2'b11:   hit = !old_v && now_v;
                    default: hit = 1'b0;
                endcase
                if (md == 2'b00)          mflag[i] = 1'b0;
                else if (hit && !sleep_i) mflag[i] = 1'b1;
                else if (clr_i[i] || ack_i[i]) mflag[i] = 1'b0;
            end
        end
    end

    always @(posedge clk_wdt) begin
        if (!rst_n) begin
            mcnt[0] = 0;
            mcnt[1] = 0;
            mwake   = 1'b0;
        end else begin
            bit completed;
            completed = 0;
            for (int i = 0; i < 2; i++) begin
                if (sleep_i && sense_i[2*i +: 2] == 2'b00 && mask_i[i] && !pin_i[i]) begin
                    if (mcnt[i] == 1) completed = 1;
                    if (mcnt[i] < 2) mcnt[i] = mcnt[i] + 1;
                end else begin
                    mcnt[i] = 0;
                end
            end
            if (start_done_i)   mwake = 1'b0;
            else if (completed) mwake = 1'b1;
        end
    end

    // Per-cycle comparison of all outputs with the model (R2 R3 R5 R8 R9).
    always @(negedge clk_io) begin
        if (rst_n && !done) begin
            logic [1:0] ep;
            logic       ei;
            for (int i = 0; i < 2; i++) begin
                if (sense_i[2*i +: 2] == 2'b00)
                    ep[i] = !hist[1][i] && !sleep_i && !mwake;
                else
                    ep[i] = mflag[i];
            end
            ei = gie_i && |(ep & mask_i);
            n_checks++;
            if (pend_o !== ep || irq_o !== ei || wake_o !== mwake) begin
                n_fail++;
                $display("FAIL R2/R3/R5/R8/R9 model compare at %0t: pend=%b irq=%b wake=%b expected pend=%b irq=%b wake=%b",
                         $time, pend_o, irq_o, wake_o, ep, ei, mwake);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk_io);
        #1;
    endtask

    task automatic wdt_step;
        @(posedge clk_wdt);
        #1;
    endtask

    task automatic finish_run;
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R9 run did not complete: got hang expected finish");
            finish_run();
        end
    end

    // ---------------- directed stimulus ----------------
    initial begin
        rst_n = 1'b0;
        pin_i = 2'b11;
        sense_i = 4'b11_10;       // pin1 rising, pin0 falling
        mask_i = 2'b11;
        gie_i = 1'b1;
        clr_i = 2'b00;
        ack_i = 2'b00;
        sleep_i = 1'b0;
        start_done_i = 1'b0;
        cyc(10);
        rst_n = 1'b1;
        cyc(1);
        chk(pend_o[0], 1'b0, "R10 pend0 after reset");
        chk(pend_o[1], 1'b0, "R10 pend1 after reset");
        chk(irq_o, 1'b0, "R10 irq after reset");
        chk(wake_o, 1'b0, "R10 wake after reset");

        // Falling edge on pin0: flag on the third edge.
        pin_i[0] = 1'b0;
        cyc(2);
        chk(pend_o[0], 1'b0, "R3 flag not before third edge");
        cyc(1);
        chk(pend_o[0], 1'b1, "R3 falling edge flag");
        chk(irq_o, 1'b1, "R2 irq from pin0");
        cyc(20);
        chk(pend_o[0], 1'b1, "R6 flag held");

        clr_i[0] = 1'b1;
        cyc(1);
        clr_i[0] = 1'b0;
        chk(pend_o[0], 1'b0, "R4 clear strobe");

        // Rising edge on a falling-mode pin is ignored.
        pin_i[0] = 1'b1;
        cyc(4);
        chk(pend_o[0], 1'b0, "R1 falling mode ignores rise");

        // One-cycle low pulse on rising-mode pin1.
        pin_i[1] = 1'b0;
        cyc(1);
        pin_i[1] = 1'b1;
        cyc(4);
        chk(pend_o[1], 1'b1, "R3 one-cycle pulse caught");
        ack_i[1] = 1'b1;
        cyc(1);
        ack_i[1] = 1'b0;
        chk(pend_o[1], 1'b0, "R4 acknowledge clears");

        // Masking and global enable.
        mask_i = 2'b00;
        pin_i[1] = 1'b0;
        cyc(1);
        pin_i[1] = 1'b1;
        cyc(4);
        chk(pend_o[1], 1'b1, "R2 masked pin still pending");
        chk(irq_o, 1'b0, "R2 masked pin no irq");
        mask_i = 2'b10;
        gie_i = 1'b0;
        cyc(1);
        chk(irq_o, 1'b0, "R2 global enable off");
        gie_i = 1'b1;
        cyc(1);
        chk(irq_o, 1'b1, "R2 global enable on");
        ack_i[1] = 1'b1;
        cyc(1);
        ack_i[1] = 1'b0;

        // Clear on the same edge as a new detection: detection wins.
        pin_i[1] = 1'b0;
        cyc(1);
        pin_i[1] = 1'b1;
        cyc(2);
        clr_i[1] = 1'b1;
        cyc(1);
        clr_i[1] = 1'b0;
        chk(pend_o[1], 1'b1, "R4 detection beats clear");
        clr_i[1] = 1'b1;
        cyc(1);
        clr_i[1] = 1'b0;
        chk(pend_o[1], 1'b0, "R4 later clear");

        // Any-change mode on pin0.
        mask_i = 2'b11;
        sense_i[1:0] = 2'b01;
        cyc(4);
        chk(pend_o[0], 1'b0, "R1 any-change quiet pin");
        pin_i[0] = 1'b0;
        cyc(3);
        chk(pend_o[0], 1'b1, "R1 any-change on fall");
        clr_i[0] = 1'b1;
        cyc(1);
        clr_i[0] = 1'b0;
        pin_i[0] = 1'b1;
        cyc(3);
        chk(pend_o[0], 1'b1, "R1 any-change on rise");
        clr_i[0] = 1'b1;
        cyc(1);
        clr_i[0] = 1'b0;

        // Low-level mode on pin0.
        sense_i[1:0] = 2'b00;
        cyc(2);
        chk(pend_o[0], 1'b0, "R5 high pin no request");
        pin_i[0] = 1'b0;
        cyc(1);
        chk(pend_o[0], 1'b0, "R5 level after two edges only");
        cyc(1);
        chk(pend_o[0], 1'b1, "R5 level request");
        chk(irq_o, 1'b1, "R2 irq from level");
        cyc(10);
        chk(pend_o[0], 1'b1, "R5 request held while low");
        pin_i[0] = 1'b1;
        cyc(2);
        chk(pend_o[0], 1'b0, "R5 no latch after release");

        // Sleep: edges ignored.
        sleep_i = 1'b1;
        pin_i[1] = 1'b0;
        cyc(1);
        pin_i[1] = 1'b1;
        cyc(5);
        chk(pend_o[1], 1'b0, "R7 edge ignored in sleep");

        // Single low sample must not wake.
        wdt_step();
        pin_i[0] = 1'b0;
        wdt_step();
        chk(wake_o, 1'b0, "R8 one sample no wake");
        chk(pend_o[0], 1'b0, "R7 level quiet in sleep");
        pin_i[0] = 1'b1;
        wdt_step();
        chk(wake_o, 1'b0, "R8 run broken no wake");

        // Two samples wake; level released before start-up ends.
        pin_i[0] = 1'b0;
        wdt_step();
        chk(wake_o, 1'b0, "R8 first of two samples");
        wdt_step();
        chk(wake_o, 1'b1, "R8 wake after two samples");
        chk(pend_o[0], 1'b0, "R7 level held off in sleep");
        pin_i[0] = 1'b1;
        sleep_i = 1'b0;
        cyc(3);
        chk(wake_o, 1'b1, "R9 wake held until start-up ends");
        chk(irq_o, 1'b0, "R9 no irq during start-up");
        start_done_i = 1'b1;
        wdt_step();
        start_done_i = 1'b0;
        chk(wake_o, 1'b0, "R9 wake released");
        cyc(3);
        chk(pend_o[0], 1'b0, "R9 wake without interrupt");
        chk(irq_o, 1'b0, "R9 no irq after released level");

        // Level still low at end of start-up raises the interrupt.
        sleep_i = 1'b1;
        pin_i[0] = 1'b0;
        wdt_step();
        wdt_step();
        chk(wake_o, 1'b1, "R8 second wake");
        sleep_i = 1'b0;
        cyc(3);
        chk(pend_o[0], 1'b0, "R9 level suppressed before start-up ends");
        start_done_i = 1'b1;
        wdt_step();
        start_done_i = 1'b0;
        chk(wake_o, 1'b0, "R9 second wake released");
        chk(pend_o[0], 1'b1, "R9 level seen after start-up");
        chk(irq_o, 1'b1, "R9 irq after start-up");

        // Masked level pin cannot wake.
        mask_i = 2'b10;
        sleep_i = 1'b1;
        wdt_step();
        wdt_step();
        wdt_step();
        chk(wake_o, 1'b0, "R8 masked pin no wake");
        sleep_i = 1'b0;
        pin_i[0] = 1'b1;
        cyc(5);
        finish_run();
    end

endmodule